// File: doc/BRIEF.md
# Attribute-Driven Data Cache Controller

This block is the control side of a small set-associative data cache. It serves one CPU data access at a time: a load, a store or a swap half. It keeps the tag, valid and per-half dirty state itself. The data storage, the write buffer and the bus burst engine sit outside it and are driven through request outputs.

Each access carries two region attributes, cacheable and bufferable. A global enable bit also applies. The cacheable attribute is ANDed with the global enable and then paired with the bufferable attribute. That pair picks one of four behaviours:

- uncached and unbuffered
- uncached but buffered
- write-through
- write-back

Lookups happen whenever the global enable is set, even in regions marked uncached. Allocation happens only on cacheable read misses. Before a line is replaced, its dirty halves are sent to the write buffer as one burst of half a line or a whole line. Only then is the linefill requested.

The line to replace is chosen among the ways that are not locked. A configuration input selects between two policies: a per-set round-robin pointer, or a free-running LFSR.

Top module: `dc_ctrl`

## Requirements
- R1: The access policy is the 2-bit code {rgn_c AND cache_en, rgn_b}. The codes are: 00 uncached-unbuffered, 01 uncached-buffered, 10 write-through, 11 write-back. Reads in either uncached code, and writes in code 00, go to the single-access bus channel. Writes in code 01 go to the write buffer.
- R2: With cache_en low, no lookup takes place. cpu_hit and hit_err stay low even for an address whose line is resident.
- R3: With cache_en high and a policy code of 00 or 01, the cache is still searched. A hit pulses hit_err in the cycle after acceptance. The access still completes over the bus or the write buffer, and no line is allocated.
- R4: A single-access bus transfer raises nc_req, with nc_we equal to cpu_we and nc_addr equal to cpu_addr, in the cycle after acceptance. stall is held high until nc_ack is sampled. cpu_done follows one cycle after nc_ack.
- R5: A write with code 01 gives wb_push with wb_len=1 and wb_addr=cpu_addr, together with cpu_done, one cycle after acceptance. stall stays low.
- R6: A read hit with code 10 or 11 gives cpu_done and cpu_hit one cycle after acceptance. There is no write-buffer or bus request.
- R7: A cacheable read miss raises stall and then fill_req. fill_addr is the line base, with word offset bits 2:0 equal to zero. fill_req is held until fill_done. cpu_done follows one cycle after fill_done, and the line hits afterwards.
- R8: Every write with code 10 gives one wb_push with wb_len=1. A hit reports cpu_hit and leaves the line clean.
- R9: In code 11, a write hit sets the dirty bit of the half it touches (address bit 2 picks the upper half) and makes no write-buffer push. A write miss pushes one word with wb_len=1 and does not allocate.
- R10: When a dirty victim is replaced, one wb_push is issued in the first stall cycle, followed by fill_req in the next cycle. If both halves are dirty, wb_len=8 at the victim line base. If only one half is dirty, wb_len=4 at the base of that half (base+4 for the upper half).
- R11: Victims come only from ways whose lock_mask bit is 0. If every way is locked, a cacheable read miss is served as a single bus read without allocation.
- R12: With repl_rr=1, each set's pointer starts at way 0. The victim is the first unlocked way at or after the pointer. The pointer then moves to the way after the victim.
- R13: stall and cpu_done are never high together. stall is high throughout every linefill and every single-access bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Global cache enable |
| rgn_c | input | 1 | Region cacheable attribute |
| rgn_b | input | 1 | Region bufferable attribute |
| repl_rr | input | 1 | 1 selects round-robin replacement, 0 selects LFSR |
| lock_mask | input | WAYS | Per-way lock, 1 excludes the way from replacement |
| cpu_req | input | 1 | Access request, accepted only while idle |
| cpu_we | input | 1 | 1 for a store |
| cpu_addr | input | ADDR_W | Word address |
| cpu_done | output | 1 | Access completion pulse |
| cpu_hit | output | 1 | Cache hit, valid with cpu_done |
| stall | output | 1 | CPU must wait |
| hit_err | output | 1 | Hit in an uncached region |
| wb_push | output | 1 | Write-buffer entry pulse |
| wb_addr | output | ADDR_W | Start address of the entry |
| wb_len | output | log2(LINE_WORDS)+1 | Words in the entry: 1, half line or full line |
| fill_req | output | 1 | Linefill burst request |
| fill_addr | output | ADDR_W | Line base of the fill |
| fill_done | input | 1 | Linefill complete |
| nc_req | output | 1 | Single-access bus request |
| nc_we | output | 1 | Direction of the single access |
| nc_addr | output | ADDR_W | Address of the single access |
| nc_ack | input | 1 | Single access complete |

## Verification
Results that need no bus wait appear in the cycle after the request edge. These are hits, buffered writes, hit_err and the write-back push. The bench reads them at the falling edge that follows that request edge. For linefills and single bus transfers, the bench answers fill_req or nc_req at the falling edge where it first sees the request. It then expects cpu_done at the next falling edge, after the design has registered the answer. Every output seen between acceptance and completion is recorded. The record is compared with a reference state that the bench keeps from the requirements, so a push or request in the wrong cycle or in the wrong access shows up as a mismatch.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    M_NCNB = 2'b00,
    M_NCB  = 2'b01,
    M_WT   = 2'b10,
    M_WB   = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FILLGO,
    S_FILLWAIT,
    S_NCWAIT
  } state_t;
endpackage

// File: rtl/dc_policy.sv
module dc_policy (
  input  logic          cache_en,
  input  logic          rgn_c,
  input  logic          rgn_b,
  output dc_pkg::mode_t mode,
  output logic          lookup
);
  always_comb begin
    mode   = dc_pkg::mode_t'({rgn_c & cache_en, rgn_b});
    lookup = cache_en;
  end
endmodule

// File: rtl/dc_lfsr.sv
module dc_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= W'(1);
    else     q <= {q[W-2:0], ^(q & TAPS)};
  end
endmodule

// File: rtl/dc_victim.sv
module dc_victim #(
  parameter int WAYS = 2,
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] lock_mask,
  input  logic [WW-1:0]   start,
  output logic [WW-1:0]   victim,
  output logic            found
);
  logic [WW-1:0] cand;

  always_comb begin
    found  = 1'b0;
    victim = start;
    cand   = '0;
    for (int k = 0; k < WAYS; k++) begin
      cand = start + WW'(k);
      if (!found && !lock_mask[cand]) begin
        victim = cand;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 8,
  parameter int LFSR_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cache_en,
  input  logic                          rgn_c,
  input  logic                          rgn_b,
  input  logic                          repl_rr,
  input  logic [WAYS-1:0]               lock_mask,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  output logic                          cpu_done,
  output logic                          cpu_hit,
  output logic                          stall,
  output logic                          hit_err,
  output logic                          wb_push,
  output logic [ADDR_W-1:0]             wb_addr,
  output logic [$clog2(LINE_WORDS):0]   wb_len,
  output logic                          fill_req,
  output logic [ADDR_W-1:0]             fill_addr,
  input  logic                          fill_done,
  output logic                          nc_req,
  output logic                          nc_we,
  output logic [ADDR_W-1:0]             nc_addr,
  input  logic                          nc_ack
);
  import dc_pkg::*;

  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WW    = $clog2(WAYS);
  localparam int LEN_W = OFF_W + 1;

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [1:0]       dirty_q [SETS][WAYS];
  logic [WW-1:0]    rr_q    [SETS];

  state_t           state;
  logic [WW-1:0]    vic_q;
  mode_t            mode;
  logic             lookup;
  logic [LFSR_W-1:0] lfsr_q;
  logic [WW-1:0]    start, victim, hit_way;
  logic             found, hit;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             half;
  logic [1:0]       vdirty;
  logic [ADDR_W-1:0] vbase;
  logic [IDX_W-1:0] fidx;
  logic [TAG_W-1:0] ftag;

  assign idx  = cpu_addr[OFF_W +: IDX_W];
  assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign half = cpu_addr[OFF_W-1];
  assign fidx = fill_addr[OFF_W +: IDX_W];
  assign ftag = fill_addr[ADDR_W-1 -: TAG_W];

  dc_policy u_policy (
    .cache_en(cache_en), .rgn_c(rgn_c), .rgn_b(rgn_b),
    .mode(mode), .lookup(lookup)
  );

  dc_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst(rst), .q(lfsr_q));

  assign start = repl_rr ? rr_q[idx] : lfsr_q[WW-1:0];

  dc_victim #(.WAYS(WAYS)) u_victim (
    .lock_mask(lock_mask), .start(start), .victim(victim), .found(found)
  );

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lookup && valid_q[idx][w] && tag_q[idx][w] == tag) begin
        hit     = 1'b1;
        hit_way = WW'(w);
      end
    end
  end

  assign vdirty = valid_q[idx][victim] ? dirty_q[idx][victim] : 2'b00;
  assign vbase  = {tag_q[idx][victim], idx, OFF_W'(0)};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cpu_done  <= 1'b0;
      cpu_hit   <= 1'b0;
      stall     <= 1'b0;
      hit_err   <= 1'b0;
      wb_push   <= 1'b0;
      wb_addr   <= '0;
      wb_len    <= '0;
      fill_req  <= 1'b0;
      fill_addr <= '0;
      nc_req    <= 1'b0;
      nc_we     <= 1'b0;
      nc_addr   <= '0;
      vic_q     <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
        for (int w = 0; w < WAYS; w++) dirty_q[s][w] <= 2'b00;
      end
    end else begin
      cpu_done <= 1'b0;
      cpu_hit  <= 1'b0;
      hit_err  <= 1'b0;
      wb_push  <= 1'b0;
      case (state)
        S_IDLE: if (cpu_req) begin
          hit_err <= hit & (mode == M_NCNB || mode == M_NCB);
          if (mode == M_NCB && cpu_we) begin
            wb_push  <= 1'b1;
            wb_addr  <= cpu_addr;
            wb_len   <= LEN_W'(1);
            cpu_done <= 1'b1;
          end else if (mode == M_NCNB || mode == M_NCB) begin
            nc_req  <= 1'b1;
            nc_we   <= cpu_we;
            nc_addr <= cpu_addr;
            stall   <= 1'b1;
            state   <= S_NCWAIT;
          end else if (cpu_we) begin
            cpu_done <= 1'b1;
            cpu_hit  <= hit;
            if (hit && mode == M_WB) begin
              dirty_q[idx][hit_way][half] <= 1'b1;
            end else begin
              wb_push <= 1'b1;
              wb_addr <= cpu_addr;
              wb_len  <= LEN_W'(1);
            end
          end else if (hit) begin
            cpu_done <= 1'b1;
            cpu_hit  <= 1'b1;
          end else if (found) begin
            vic_q     <= victim;
            fill_addr <= {tag, idx, OFF_W'(0)};
            valid_q[idx][victim] <= 1'b0;
            dirty_q[idx][victim] <= 2'b00;
            if (vdirty != 2'b00) begin
              wb_push <= 1'b1;
              wb_addr <= (vdirty == 2'b10) ? vbase + ADDR_W'(LINE_WORDS/2) : vbase;
              wb_len  <= (vdirty == 2'b11) ? LEN_W'(LINE_WORDS) : LEN_W'(LINE_WORDS/2);
            end
            stall <= 1'b1;
            state <= S_FILLGO;
          end else begin
            nc_req  <= 1'b1;
            nc_we   <= 1'b0;
            nc_addr <= cpu_addr;
            stall   <= 1'b1;
            state   <= S_NCWAIT;
          end
        end
        S_FILLGO: begin
          fill_req <= 1'b1;
          state    <= S_FILLWAIT;
        end
        S_FILLWAIT: if (fill_done) begin
          fill_req              <= 1'b0;
          tag_q[fidx][vic_q]    <= ftag;
          valid_q[fidx][vic_q]  <= 1'b1;
          rr_q[fidx]            <= vic_q + WW'(1);
          stall                 <= 1'b0;
          cpu_done              <= 1'b1;
          state                 <= S_IDLE;
        end
        S_NCWAIT: if (nc_ack) begin
          nc_req   <= 1'b0;
          stall    <= 1'b0;
          cpu_done <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dc_ctrl_chk.sv
module dc_ctrl_chk #(
  parameter int LINE_WORDS = 8,
  localparam int LEN_W = $clog2(LINE_WORDS) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cache_en,
  input logic             cpu_done,
  input logic             cpu_hit,
  input logic             stall,
  input logic             hit_err,
  input logic             wb_push,
  input logic [LEN_W-1:0] wb_len,
  input logic             fill_req,
  input logic             fill_done,
  input logic             nc_req
);
  assert_fill_stalls_R13: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> stall);

  assert_nc_stalls_R4: assert property (@(posedge clk) disable iff (rst)
    nc_req |-> stall);

  assert_done_unstalled_R13: assert property (@(posedge clk) disable iff (rst)
    !(cpu_done && stall));

  assert_burst_len_R10: assert property (@(posedge clk) disable iff (rst)
    wb_push |-> (wb_len == LEN_W'(1) || wb_len == LEN_W'(LINE_WORDS/2) ||
                 wb_len == LEN_W'(LINE_WORDS)));

  assert_evict_then_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (wb_push && wb_len != LEN_W'(1)) |=> fill_req);

  assert_fill_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(fill_req) |-> $past(fill_done));

  assert_no_hit_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_hit |-> $past(cache_en));

  assert_err_needs_lookup_R3: assert property (@(posedge clk) disable iff (rst)
    hit_err |-> $past(cache_en));
endmodule

bind dc_ctrl dc_ctrl_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst(rst), .cache_en(cache_en), .cpu_done(cpu_done),
  .cpu_hit(cpu_hit), .stall(stall), .hit_err(hit_err), .wb_push(wb_push),
  .wb_len(wb_len), .fill_req(fill_req), .fill_done(fill_done), .nc_req(nc_req)
);

// File: tb/dc_ctrl_test.sv
module dc_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cache_en = 1'b0, rgn_c = 1'b0, rgn_b = 1'b0, repl_rr = 1'b1;
  logic [1:0] lock_mask = 2'b00;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic cpu_done, cpu_hit, stall, hit_err, wb_push, fill_req, nc_req, nc_we;
  logic [11:0] wb_addr, fill_addr, nc_addr;
  logic [3:0] wb_len;
  logic fill_done = 1'b0, nc_ack = 1'b0;

  int total = 0;
  int bad = 0;

  // reference state
  bit       mv [4][2];
  bit [6:0] mt [4][2];
  bit [1:0] md [4][2];
  int       mp [4];

  always #4 clk = ~clk;

  dc_ctrl uut (
    .clk(clk), .rst(rst), .cache_en(cache_en), .rgn_c(rgn_c), .rgn_b(rgn_b),
    .repl_rr(repl_rr), .lock_mask(lock_mask), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .stall(stall),
    .hit_err(hit_err), .wb_push(wb_push), .wb_addr(wb_addr), .wb_len(wb_len),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_done(fill_done),
    .nc_req(nc_req), .nc_we(nc_we), .nc_addr(nc_addr), .nc_ack(nc_ack)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input bit en, input bit c, input bit b, input bit we, input logic [11:0] a);
    int s = int'(a[4:3]);
    bit [6:0] t = a[11:5];
    bit h = 0;
    int hw = 0;
    bit cach = c & en;
    int e_hit = 0, e_err = 0, e_nwb = 0, e_wblen = 0, e_wbaddr = 0;
    int e_fill = 0, e_filladdr = 0, e_nc = 0, e_ncwe = 0, e_ncaddr = 0, e_stall = 0;
    int v = 0;
    bit alloc = 0;
    int o_done = 0, o_hit = 0, o_err = 0, o_nwb = 0, o_wblen = 0, o_wbaddr = 0;
    int o_fill = 0, o_filladdr = 0, o_nc = 0, o_ncwe = 0, o_ncaddr = 0, o_stall = 0;
    int o_both = 0, o_fillnostall = 0;
    string ht, wt;

    for (int w = 0; w < 2; w++)
      if (en && mv[s][w] && mt[s][w] == t) begin h = 1; hw = w; end

    // expectation from the requirements
    if (!cach) begin
      e_err = h;
      if (we && b) begin e_nwb = 1; e_wblen = 1; e_wbaddr = int'(a); wt = "R5"; end
      else begin e_nc = 1; e_ncwe = we; e_ncaddr = int'(a); e_stall = 1; wt = "R1"; end
    end else if (we) begin
      e_hit = h;
      if (h && b) begin md[s][hw][a[2]] = 1'b1; wt = "R9"; end
      else begin e_nwb = 1; e_wblen = 1; e_wbaddr = int'(a); wt = b ? "R9" : "R8"; end
    end else if (h) begin
      e_hit = 1; wt = "R6";
    end else if (lock_mask != 2'b11) begin
      int st = repl_rr ? mp[s] : 0;
      bit got = 0;
      for (int k = 0; k < 2; k++) begin
        int cw = (st + k) % 2;
        if (!got && !lock_mask[cw]) begin v = cw; got = 1; end
      end
      alloc = 1; e_fill = 1; e_stall = 1;
      e_filladdr = int'({t, a[4:3], 3'b000});
      if (mv[s][v] && md[s][v] != 2'b00) begin
        e_nwb = 1;
        e_wblen = (md[s][v] == 2'b11) ? 8 : 4;
        e_wbaddr = int'({mt[s][v], a[4:3], 3'b000}) + ((md[s][v] == 2'b10) ? 4 : 0);
      end
      wt = "R10";
    end else begin
      e_nc = 1; e_ncwe = 0; e_ncaddr = int'(a); e_stall = 1; wt = "R11";
    end

    // drive the access
    @(negedge clk);
    cache_en = en; rgn_c = c; rgn_b = b;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    o_stall = int'(stall);
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (cpu_done && stall) o_both = 1;
      if (fill_req && !stall) o_fillnostall = 1;
      if (wb_push) begin o_nwb++; o_wblen = int'(wb_len); o_wbaddr = int'(wb_addr); end
      if (hit_err) o_err = 1;
      if (fill_req) begin o_fill = 1; o_filladdr = int'(fill_addr); fill_done = 1'b1; end
      else fill_done = 1'b0;
      if (nc_req) begin o_nc = 1; o_ncwe = int'(nc_we); o_ncaddr = int'(nc_addr); nc_ack = 1'b1; end
      else nc_ack = 1'b0;
      if (cpu_done) begin o_done = 1; o_hit = int'(cpu_hit); break; end
      @(negedge clk);
    end
    fill_done = 1'b0;
    nc_ack = 1'b0;

    if (alloc) begin
      mv[s][v] = 1; mt[s][v] = t; md[s][v] = 2'b00; mp[s] = (v + 1) % 2;
    end

    ht = !en ? "R2" : (!cach ? "R3" : (repl_rr ? "R6/R12" : "R6/R11"));
    check("R13", "done seen", o_done, 1);
    check("R13", "stall with done", o_both, 0);
    check("R13", "fill without stall", o_fillnostall, 0);
    check("R13", "stall after accept", o_stall, e_stall);
    check(ht, "hit", o_hit, e_hit);
    check(en ? "R3" : "R2", "hit_err", o_err, e_err);
    check(wt, "wb pushes", o_nwb, e_nwb);
    if (e_nwb != 0 && o_nwb != 0) begin
      check(wt, "wb_len", o_wblen, e_wblen);
      check(wt, "wb_addr", o_wbaddr, e_wbaddr);
    end
    check("R7", "fill seen", o_fill, e_fill);
    if (e_fill != 0 && o_fill != 0) check("R7", "fill_addr", o_filladdr, e_filladdr);
    check("R4", "nc seen", o_nc, e_nc);
    if (e_nc != 0 && o_nc != 0) begin
      check("R4", "nc_we", o_ncwe, e_ncwe);
      check("R4", "nc_addr", o_ncaddr, e_ncaddr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R13 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      mp[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; mt[s][w] = 0; md[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R13", "reset stall", int'(stall), 0);
    check("R13", "reset done", int'(cpu_done), 0);
    check("R7", "reset fill_req", int'(fill_req), 0);
    check("R4", "reset nc_req", int'(nc_req), 0);
    check("R5", "reset wb_push", int'(wb_push), 0);
    check("R3", "reset hit_err", int'(hit_err), 0);

    // sweep: lock/policy configurations x addresses x modes x direction
    for (int cfg = 0; cfg < 5; cfg++) begin
      case (cfg)
        0: begin lock_mask = 2'b00; repl_rr = 1'b1; end
        1: begin lock_mask = 2'b01; repl_rr = 1'b1; end
        2: begin lock_mask = 2'b10; repl_rr = 1'b0; end
        3: begin lock_mask = 2'b11; repl_rr = 1'b1; end
        default: begin lock_mask = 2'b00; repl_rr = 1'b1; end
      endcase
      for (int t = 0; t < 3; t++)
        for (int s = 0; s < 4; s++)
          for (int m = 0; m < 8; m++)
            for (int we = 0; we < 2; we++)
              for (int o = 0; o < 2; o++)
                run(m[2], m[1], m[0], we[0],
                    {t[6:0], s[1:0], (o == 0) ? 3'd1 : 3'd6});
    end

    // single dirty halves: lower, then upper
    lock_mask = 2'b00; repl_rr = 1'b1;
    for (int hsel = 0; hsel < 2; hsel++) begin
      for (int t = 8; t < 10; t++) begin
        run(1, 1, 1, 0, {7'(t), 2'd2, 3'd0});
        run(1, 1, 1, 1, {7'(t), 2'd2, (hsel == 0) ? 3'd2 : 3'd5});
      end
      run(1, 1, 1, 0, {7'd10, 2'd2, 3'd0});
      run(1, 1, 1, 0, {7'd11, 2'd2, 3'd0});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule